// File: doc/BRIEF.md
# Mask-Write GPIO Bank Controller

This block runs one bank of up to 32 general-purpose pins behind a small register bus. Software can set or clear single output bits without a read-modify-write, because each half-word data write carries its own 16-bit protect mask in the upper half of the word. A full-width output register, a direction register and an enable register complete the write side. A read-only pin-level register returns what each pin currently shows.

The pad drive enable for a pin is the AND of its direction and enable bits. External inputs pass through a two-stage synchronizer before software can see them. The `PINS` parameter sets how many pins exist; bits at or above `PINS` always read 0 and take no writes. The bus uses word indices: index k corresponds to byte offset 4*k. Writes take effect at the clock edge that samples `wr_en`. Read data is registered and appears one cycle after `rd_en`.

Top module: `gpio_mw_bank`

## Requirements
- R1: After a synchronous reset, the output, direction and enable registers and `rdata` are zero, and `pad_out` and `pad_oe` are all low.
- R2: A write to index 0 updates output bit i (i = 0..15) to `wdata[i]` when `wdata[16+i]` is 0. When `wdata[16+i]` is 1, bit i keeps its value. Bits 16..31 are untouched.
- R3: A write to index 1 updates output bit 16+i to `wdata[i]` when `wdata[16+i]` is 0. When `wdata[16+i]` is 1, bit 16+i keeps its value. Bits 0..15 are untouched.
- R4: Index 2 is the full-width output register. A write replaces every implemented bit, and a read returns its value.
- R5: Index 3 is a read-only pin-level register. For a driven pin it returns the output bit; otherwise it returns `pad_in` after a two-flop synchronizer. A write to index 3 changes nothing.
- R6: Index 4 is the direction register and index 5 the enable register (1 = output / enabled); both can be read back. `pad_oe[i]` equals `dir[i] AND en[i]`, one clock after the register write lands.
- R7: `pad_out` follows the output register at the write edge, and changes only on writes to indices 0, 1 or 2.
- R8: `rdata` is loaded at the clock edge that samples `rd_en`. Indices 0 and 1 are write-only, and they and the unused indices 6 and 7 read 0.
- R9: Bits at or above `PINS` read 0 in every register and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| widx | input | 3 | Write register index |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| ridx | input | 3 | Read register index |
| rdata | output | 32 | Registered read data |
| pad_in | input | PINS | External pin levels |
| pad_out | output | PINS | Pad output values |
| pad_oe | output | PINS | Pad drive enables |

## Verification
On every cycle, the assertions check the following:
- the masked half-word update and hold rules on the output register;
- that the output register stays stable unless a data index is written;
- that drive enables never exceed the previous direction and enable bits;
- that write-only and unused indices read zero;
- that no bit above `PINS` is ever set.

Only the bench scenarios can show the rest:
- the synchronizer latency on `pad_in`;
- the mix of driven and input values in the pin-level register;
- that writes to the read-only index are dropped;
- the behaviour of the reduced-width instance against a reference model under random traffic.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam int IDX_W  = 3;
  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_LO  = 3'd0,
    IDX_HI  = 3'd1,
    IDX_OUT = 3'd2,
    IDX_PIN = 3'd3,
    IDX_DIR = 3'd4,
    IDX_EN  = 3'd5
  } reg_idx_e;

  // Keep bits whose protect bit is set, take new data where it is clear.
  function automatic logic [HALF_W-1:0] merge_half(input logic [HALF_W-1:0] cur,
                                                   input logic [BUS_W-1:0]  word);
    return (cur & word[BUS_W-1:HALF_W]) | (word[HALF_W-1:0] & ~word[BUS_W-1:HALF_W]);
  endfunction

  function automatic logic [BUS_W-1:0] impl_mask(input int n);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < BUS_W; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_mw_regs.sv
module gpio_mw_regs import gpio_mw_pkg::*; #(
  parameter int PINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] widx,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] out_q,
  output logic [BUS_W-1:0] dir_q,
  output logic [BUS_W-1:0] en_q,
  output logic [BUS_W-1:0] drive_q
);
  localparam logic [BUS_W-1:0] IMPL = impl_mask(PINS);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '0;
      en_q    <= '0;
      drive_q <= '0;
    end else begin
      drive_q <= dir_q & en_q;
      if (wr_en) begin
        case (widx)
          IDX_LO:  out_q <= {out_q[BUS_W-1:HALF_W], merge_half(out_q[HALF_W-1:0], wdata)} & IMPL;
          IDX_HI:  out_q <= {merge_half(out_q[BUS_W-1:HALF_W], wdata), out_q[HALF_W-1:0]} & IMPL;
          IDX_OUT: out_q <= wdata & IMPL;
          IDX_DIR: dir_q <= wdata & IMPL;
          IDX_EN:  en_q  <= wdata & IMPL;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_mw_rdmux.sv
module gpio_mw_rdmux import gpio_mw_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] ridx,
  input  logic [BUS_W-1:0] out_q,
  input  logic [BUS_W-1:0] dir_q,
  input  logic [BUS_W-1:0] en_q,
  input  logic [BUS_W-1:0] pin_view,
  output logic [BUS_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (ridx)
        IDX_OUT: rdata <= out_q;
        IDX_PIN: rdata <= pin_view;
        IDX_DIR: rdata <= dir_q;
        IDX_EN:  rdata <= en_q;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank import gpio_mw_pkg::*; #(
  parameter int PINS      = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] widx,
  input  logic [BUS_W-1:0] wdata,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] ridx,
  output logic [BUS_W-1:0] rdata,
  input  logic [PINS-1:0]  pad_in,
  output logic [PINS-1:0]  pad_out,
  output logic [PINS-1:0]  pad_oe
);
  logic [BUS_W-1:0] out_q, dir_q, en_q, drive_q;
  logic [PINS-1:0]  sync_q;
  logic [BUS_W-1:0] pin_in_w, pin_view;

  gpio_mw_sync #(.W(PINS), .STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
  );

  gpio_mw_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .widx(widx), .wdata(wdata),
    .out_q(out_q), .dir_q(dir_q), .en_q(en_q), .drive_q(drive_q)
  );

  always_comb begin
    pin_in_w = '0;
    pin_in_w[PINS-1:0] = sync_q;
  end

  // Driven pins report their own output value, others the synchronized input.
  assign pin_view = (drive_q & out_q) | (~drive_q & pin_in_w);

  gpio_mw_rdmux u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .ridx(ridx),
    .out_q(out_q), .dir_q(dir_q), .en_q(en_q), .pin_view(pin_view),
    .rdata(rdata)
  );

  assign pad_out = out_q[PINS-1:0];
  assign pad_oe  = drive_q[PINS-1:0];
endmodule

// File: rtl/gpio_mw_bank_chk.sv
module gpio_mw_bank_chk import gpio_mw_pkg::*; #(
  parameter int PINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] widx,
  input logic [BUS_W-1:0] wdata,
  input logic             rd_en,
  input logic [IDX_W-1:0] ridx,
  input logic [BUS_W-1:0] rdata,
  input logic [BUS_W-1:0] out_q,
  input logic [BUS_W-1:0] dir_q,
  input logic [BUS_W-1:0] en_q,
  input logic [BUS_W-1:0] drive_q
);
  localparam logic [BUS_W-1:0] IMPL = impl_mask(PINS);

  // R2
  lo_update_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && widx == IDX_LO) |=>
      (((out_q[15:0] ^ $past(wdata[15:0])) & ~$past(wdata[31:16]) & IMPL[15:0]) == 16'd0));

  // R2
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && widx == IDX_LO) |=>
      ((((out_q[15:0] ^ $past(out_q[15:0])) & $past(wdata[31:16])) == 16'd0)
       && $stable(out_q[31:16])));

  // R3
  hi_update_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && widx == IDX_HI) |=>
      ((((out_q[31:16] ^ $past(wdata[15:0])) & ~$past(wdata[31:16]) & IMPL[31:16]) == 16'd0)
       && $stable(out_q[15:0])));

  // R7
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (widx == IDX_LO || widx == IDX_HI || widx == IDX_OUT)) |=> $stable(out_q));

  // R6
  drive_subset_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((drive_q & ~($past(dir_q) & $past(en_q))) == '0));

  // R8
  wo_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (ridx == IDX_LO || ridx == IDX_HI || ridx > IDX_EN)) |=> (rdata == '0));

  // R9
  impl_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ((rdata | out_q | drive_q | dir_q | en_q) & ~IMPL) == '0);
endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .widx(widx), .wdata(wdata),
  .rd_en(rd_en), .ridx(ridx), .rdata(rdata),
  .out_q(out_q), .dir_q(dir_q), .en_q(en_q), .drive_q(drive_q)
);

// File: tb/gpio_mw_bank_test.sv
`timescale 1ns/1ps
module gpio_mw_bank_test;
  localparam logic [31:0] NMASK = 32'h003F_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  widx = '0, ridx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rdata, rdata_n;
  logic [31:0] pad_out, pad_oe;
  logic [21:0] pad_out_n, pad_oe_n;

  logic [31:0] m_out = '0, m_dir = '0, m_en = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_mw_bank #(.PINS(32)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .widx(widx), .wdata(wdata),
    .rd_en(rd_en), .ridx(ridx), .rdata(rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_mw_bank #(.PINS(22)) uut_n (
    .clk(clk), .rst(rst), .wr_en(wr_en), .widx(widx), .wdata(wdata),
    .rd_en(rd_en), .ridx(ridx), .rdata(rdata_n),
    .pad_in(pad_in[21:0]), .pad_out(pad_out_n), .pad_oe(pad_oe_n)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; widx = i; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (i)
      3'd0: m_out[15:0]  = (m_out[15:0]  & d[31:16]) | (d[15:0] & ~d[31:16]);
      3'd1: m_out[31:16] = (m_out[31:16] & d[31:16]) | (d[15:0] & ~d[31:16]);
      3'd2: m_out = d;
      3'd4: m_dir = d;
      3'd5: m_en  = d;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [2:0] i, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk);
    rd_en = 1'b1; ridx = i;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; dn = rdata_n;
  endtask

  function automatic logic [31:0] exp_pins();
    logic [31:0] drv;
    drv = m_dir & m_en;
    return (drv & m_out) | (~drv & pad_in);
  endfunction

  // Full comparison of both instances against the model.
  task automatic verify_all(input string tag);
    logic [31:0] d, dn;
    repeat (3) @(negedge clk);
    check({tag, " R7 pad_out"}, pad_out, m_out);
    check({tag, " R6 pad_oe"}, pad_oe, m_dir & m_en);
    check({tag, " R9 pad_out narrow"}, {10'd0, pad_out_n}, m_out & NMASK);
    check({tag, " R9 pad_oe narrow"}, {10'd0, pad_oe_n}, m_dir & m_en & NMASK);
    bus_rd(3'd2, d, dn);
    check({tag, " R4 out read"}, d, m_out);
    check({tag, " R9 out read narrow"}, dn, m_out & NMASK);
    bus_rd(3'd4, d, dn);
    check({tag, " R6 dir read"}, d, m_dir);
    check({tag, " R9 dir narrow"}, dn, m_dir & NMASK);
    bus_rd(3'd5, d, dn);
    check({tag, " R6 en read"}, d, m_en);
    check({tag, " R9 en narrow"}, dn, m_en & NMASK);
    bus_rd(3'd3, d, dn);
    check({tag, " R5 pin read"}, d, exp_pins());
    check({tag, " R9 pin narrow"}, dn, exp_pins() & NMASK);
  endtask

  initial begin
    logic [31:0] d, dn;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pad_out", pad_out, 32'd0);
    check("R1 pad_oe", pad_oe, 32'd0);
    check("R1 rdata", rdata, 32'd0);
    verify_all("R1");

    // R4 full write
    bus_wr(3'd2, 32'hA5A5_F00F);
    check("R4 pad_out at edge", pad_out, 32'hA5A5_F00F);
    verify_all("R4");

    // R2 lower half: mask 0x00FF protects bits 0..7
    bus_wr(3'd0, 32'h00FF_1234);
    check("R2 masked low", pad_out, 32'hA5A5_120F);
    bus_wr(3'd0, 32'hFFFF_0000);
    check("R2 full protect", pad_out, 32'hA5A5_120F);
    bus_wr(3'd0, 32'h0000_BEEF);
    check("R2 no protect", pad_out, 32'hA5A5_BEEF);

    // R3 upper half: mask 0xF0F0
    bus_wr(3'd1, 32'hF0F0_0000);
    check("R3 masked high", pad_out, 32'hA0A0_BEEF);
    verify_all("R3");

    // R5 write to read-only index ignored
    bus_wr(3'd3, 32'hFFFF_FFFF);
    check("R5 write ignored", pad_out, 32'hA0A0_BEEF);

    // R6 direction alone does not drive
    bus_wr(3'd4, 32'h0000_FFFF);
    @(negedge clk);
    check("R6 dir only", pad_oe, 32'd0);
    bus_wr(3'd5, 32'h00FF_00FF);
    check("R6 lag", pad_oe, 32'd0);
    @(negedge clk);
    check("R6 oe", pad_oe, 32'h0000_00FF);

    // R5 synchronizer and mixed view
    pad_in = 32'h1234_5678;
    verify_all("R5");

    // R8 write-only and unused indices
    for (int i = 0; i < 8; i++) begin
      if (i == 0 || i == 1 || i == 6 || i == 7) begin
        bus_rd(3'(i), d, dn);
        check("R8 zero read", d, 32'd0);
      end
    end

    // R9 narrow instance ignores upper bits
    bus_wr(3'd2, 32'hFFFF_FFFF);
    bus_rd(3'd2, d, dn);
    check("R9 narrow out", dn, 32'h003F_FFFF);

    // Random traffic
    for (int k = 0; k < 150; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      pad_in = $urandom();
      bus_wr(op, $urandom());
      verify_all("RND");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule